// File: doc/BRIEF.md
# Rotating-Modulus Seven-Segment Digit Counter

This block drives one seven-segment digit from a counter whose wrap point changes from pass to pass. A free-running divider turns the system clock into a strobe. The strobe is high for one cycle out of every `TICK_MAX + 1` cycles. Each strobe moves the digit forward by one.

The digit does not always wrap at the same value. The first pass counts 0 to 6, and the next three passes end at 7, 8 and 9. After the 0-to-9 pass the sequence returns to 0-to-6 and repeats. The digit value goes through a segment decoder to give active-low drive with the decimal point dark. The raw digit value is also brought out so that the sequence can be observed.

The block is used as a visible self-test pattern on a board display. With a 50 MHz clock and the default divider it advances about twice a second. A test uses a tiny divider.

Top module: `rot_digit_display`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, the digit is 0, the segment bus is 8'hC0 and the wrap limit is 6.
- R2: The digit changes only on clock edges that are a multiple of `TICK_MAX + 1` rising edges after reset release. The first change happens on edge `TICK_MAX + 1`.
- R3: On a strobe, a digit below the current limit increases by exactly one.
- R4: On a strobe, a digit equal to the current limit returns to 0.
- R5: Each wrap with the limit below 9 raises the limit by one, so successive passes end at 6, 7, 8 and 9.
- R6: A wrap with the limit at 9 sets the limit back to 6, so the pass that follows the 0-to-9 pass ends at 6.
- R7: The segment bus carries active-low patterns with bit 7 (decimal point) high. The codes are 0=C0, 1=F9, 2=A4, 3=B0, 4=99, 5=92, 6=82, 7=F8, 8=80 and 9=90 in hex.
- R8: Between strobes the digit and the limit hold their values.
- R9: Reset is asynchronous. Raising it in the middle of a pass clears the digit at once, without waiting for a clock edge. The next pass then wraps at 6, whatever limit was active before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Asynchronous reset, active high |
| seg_o | output | 8 | Segment drive; bit 7 is the decimal point, bits 6..0 are g..a, active low |
| digit_o | output | DIGIT_W | Current digit value, for observation |

## Verification
The bound checker judges every strobe as it happens: the digit steps by one or wraps, the limit rises or reloads at a wrap, the state holds without a strobe, and the digit never passes the limit. The phase of the advances against reset release, and the full order of passes across more than one rotation, need a long run. So do the recovery of the 0-to-6 pass after a reset in mid-pass and the exact segment byte for each digit. Only the bench's scenarios show these.

// File: rtl/rot_digit_pkg.sv
package rot_digit_pkg;

   // Active-high pattern: bit 7 = decimal point, bits 6..0 = g f e d c b a
   function automatic logic [7:0] seg_pattern(input logic [3:0] value);
      logic [7:0] pat;
      case (value)
         4'd0:    pat = 8'h3F;
         4'd1:    pat = 8'h06;
         4'd2:    pat = 8'h5B;
         4'd3:    pat = 8'h4F;
         4'd4:    pat = 8'h66;
         4'd5:    pat = 8'h6D;
         4'd6:    pat = 8'h7D;
         4'd7:    pat = 8'h07;
         4'd8:    pat = 8'h7F;
         4'd9:    pat = 8'h6F;
         default: pat = 8'h00;   // out of range: blank
      endcase
      return pat;
   endfunction

endpackage

// File: rtl/rot_tick_gen.sv
module rot_tick_gen #(
   parameter int TICK_MAX = 25_000_000
) (
   input  logic clk_i,
   input  logic rst_i,
   output logic tick_o
);
   localparam int CW = (TICK_MAX > 0) ? $clog2(TICK_MAX + 1) : 1;
   localparam logic [CW-1:0] TOP_V = CW'(TICK_MAX);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i)
         cnt_q <= '0;
      else if (cnt_q >= TOP_V)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end

   assign tick_o = (cnt_q == TOP_V);
endmodule

// File: rtl/rot_digit_core.sv
module rot_digit_core #(
   parameter int DIGIT_W = 4,
   parameter int LIM_LO  = 6,
   parameter int LIM_HI  = 9
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic               tick_i,
   output logic [DIGIT_W-1:0] digit_o,
   output logic [DIGIT_W-1:0] limit_o
);
   localparam logic [DIGIT_W-1:0] LO_V = DIGIT_W'(LIM_LO);
   localparam logic [DIGIT_W-1:0] HI_V = DIGIT_W'(LIM_HI);

   logic [DIGIT_W-1:0] digit_q, limit_q;
   logic               at_top;

   assign at_top = (digit_q >= limit_q);

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) begin
         digit_q <= '0;
         limit_q <= LO_V;
      end else if (tick_i) begin
         if (at_top) begin
            digit_q <= '0;
            limit_q <= (limit_q < HI_V) ? limit_q + 1'b1 : LO_V;
         end else begin
            digit_q <= digit_q + 1'b1;
         end
      end
   end

   assign digit_o = digit_q;
   assign limit_o = limit_q;
endmodule

// File: rtl/rot_seg_decode.sv
module rot_seg_decode #(
   parameter int DIGIT_W     = 4,
   parameter bit SEG_ACT_LOW = 1'b1
) (
   input  logic [DIGIT_W-1:0] value_i,
   output logic [7:0]         seg_o
);
   import rot_digit_pkg::*;

   logic [3:0] nib;
   logic [7:0] pat;

   generate
      if (DIGIT_W > 4) begin : g_wide
         // any value above 9 maps to blank
         assign nib = (value_i > DIGIT_W'(9)) ? 4'hF : value_i[3:0];
         logic unused_hi;
         assign unused_hi = ^value_i[DIGIT_W-1:4];
      end else begin : g_narrow
         assign nib = 4'(value_i);
      end
   endgenerate

   assign pat = seg_pattern(nib);

   generate
      if (SEG_ACT_LOW) begin : g_low
         assign seg_o = ~pat;
      end else begin : g_high
         assign seg_o = pat;
      end
   endgenerate
endmodule

// File: rtl/rot_digit_display.sv
module rot_digit_display #(
   parameter int TICK_MAX    = 25_000_000,
   parameter int DIGIT_W     = 4,
   parameter int LIM_LO      = 6,
   parameter int LIM_HI      = 9,
   parameter bit SEG_ACT_LOW = 1'b1
) (
   input  logic               clk_i,
   input  logic               rst_i,
   output logic [7:0]         seg_o,
   output logic [DIGIT_W-1:0] digit_o
);
   initial begin
      assert (DIGIT_W >= 4) else $error("DIGIT_W must be at least 4");
      assert (LIM_LO <= LIM_HI) else $error("LIM_LO above LIM_HI");
      assert (LIM_HI <= 9) else $error("LIM_HI beyond one decimal digit");
      assert (TICK_MAX >= 0) else $error("TICK_MAX negative");
   end

   logic               tick;
   logic [DIGIT_W-1:0] digit;
   logic [DIGIT_W-1:0] limit;

   rot_tick_gen #(.TICK_MAX(TICK_MAX)) u_tick (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .tick_o(tick)
   );

   rot_digit_core #(
      .DIGIT_W(DIGIT_W), .LIM_LO(LIM_LO), .LIM_HI(LIM_HI)
   ) u_core (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .tick_i (tick),
      .digit_o(digit),
      .limit_o(limit)
   );

   rot_seg_decode #(
      .DIGIT_W(DIGIT_W), .SEG_ACT_LOW(SEG_ACT_LOW)
   ) u_seg (
      .value_i(digit),
      .seg_o  (seg_o)
   );

   assign digit_o = digit;
endmodule

// File: rtl/rot_digit_chk.sv
module rot_digit_chk #(
   parameter int DIGIT_W = 4,
   parameter int LIM_LO  = 6,
   parameter int LIM_HI  = 9
) (
   input logic               clk,
   input logic               rst,
   input logic               tick,
   input logic [DIGIT_W-1:0] digit,
   input logic [DIGIT_W-1:0] limit,
   input logic [7:0]         seg
);
   localparam logic [DIGIT_W-1:0] LO_V = DIGIT_W'(LIM_LO);
   localparam logic [DIGIT_W-1:0] HI_V = DIGIT_W'(LIM_HI);

   // R3
   step_up_chk: assert property (@(posedge clk) disable iff (rst)
      (tick && digit < limit) |=> digit == $past(digit) + 1'b1);

   // R4
   wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (tick && digit == limit) |=> digit == '0);

   // R5
   limit_rise_chk: assert property (@(posedge clk) disable iff (rst)
      (tick && digit == limit && limit < HI_V) |=> limit == $past(limit) + 1'b1);

   // R6
   limit_reload_chk: assert property (@(posedge clk) disable iff (rst)
      (tick && digit == limit && limit == HI_V) |=> limit == LO_V);

   // R8
   hold_chk: assert property (@(posedge clk) disable iff (rst)
      !tick |=> ($stable(digit) && $stable(limit)));

   // R4
   in_range_chk: assert property (@(posedge clk) disable iff (rst)
      (digit <= limit && limit >= LO_V && limit <= HI_V));

   // R7
   dp_dark_chk: assert property (@(posedge clk) disable iff (rst)
      seg[7] == 1'b1);
endmodule

bind rot_digit_display rot_digit_chk #(
   .DIGIT_W(DIGIT_W), .LIM_LO(LIM_LO), .LIM_HI(LIM_HI)
) u_chk (
   .clk  (clk_i),
   .rst  (rst_i),
   .tick (tick),
   .digit(digit),
   .limit(limit),
   .seg  (seg_o)
);

// File: tb/sim_rot_digit_display.sv
`timescale 1ns/1ps
module sim_rot_digit_display;
   localparam int TM  = 3;          // strobe every TM+1 = 4 edges
   localparam int PER = TM + 1;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] seg;
   logic [3:0] digit;

   int tests = 0;
   int fails = 0;
   int edges = 0;
   int exp_q[$];
   logic [3:0] prev_digit = 4'd0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   rot_digit_display #(.TICK_MAX(TM)) u0 (
      .clk_i  (clk),
      .rst_i  (rst),
      .seg_o  (seg),
      .digit_o(digit)
   );

   function automatic logic [7:0] exp_seg(input int d);
      case (d)
         0: return 8'hC0;  1: return 8'hF9;  2: return 8'hA4;
         3: return 8'hB0;  4: return 8'h99;  5: return 8'h92;
         6: return 8'h82;  7: return 8'hF8;  8: return 8'h80;
         9: return 8'h90;  default: return 8'hFF;
      endcase
   endfunction

   task automatic check(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // driver: expected digits for one pass ending at lim (1..lim then 0)
   task automatic push_pass(input int lim);
      for (int v = 1; v <= lim; v++) exp_q.push_back(v);
      exp_q.push_back(0);
   endtask

   always @(posedge clk or posedge rst)
      if (rst) edges <= 0; else edges <= edges + 1;

   // monitor: pops an expected item on every digit change
   always @(negedge clk) begin
      if (rst) begin
         prev_digit <= 4'd0;
      end else if (digit != prev_digit) begin
         prev_digit <= digit;
         // R2 / R8: change only on strobe edges
         check("R2 phase", edges % PER, 0);
         if (exp_q.size() == 0) begin
            check("R3/R4 unexpected change", int'(digit), -1);
         end else begin
            int e;
            e = exp_q.pop_front();
            check((e == 0) ? "R4 wrap" : "R3/R5/R6 sequence", int'(digit), e);
            // R7
            check("R7 segments", int'(seg), int'(exp_seg(e)));
         end
      end
   end

   task automatic drain;
      while (exp_q.size() != 0) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1
      check("R1 digit in reset", int'(digit), 0);
      check("R1 seg in reset", int'(seg), 8'hC0);
      rst = 1'b0;
      @(negedge clk);
      check("R1 digit after release", int'(digit), 0);
      // two rotations: R5 rises, R6 reload
      for (int r = 0; r < 2; r++)
         for (int l = 6; l <= 9; l++) push_pass(l);
      drain();
      // R6 next pass ends at 6 again, then partway into the 7 pass
      push_pass(6);
      for (int v = 1; v <= 4; v++) exp_q.push_back(v);
      drain();
      check("R8 mid-pass digit", int'(digit), 4);
      // R9 async reset mid-pass
      #2 rst = 1'b1;
      #1;
      check("R9 async clear", int'(digit), 0);
      check("R9 seg after clear", int'(seg), 8'hC0);
      repeat (6) @(posedge clk);
      @(negedge clk);
      check("R1 held in reset", int'(digit), 0);
      rst = 1'b0;
      // R9 limit back to 6: pass ends at 6, then 0..7 starts
      push_pass(6);
      exp_q.push_back(1);
      drain();
      check("R9 restart digit", int'(digit), 1);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule